// File: doc/BRIEF.md
# Dual-Issue Warp Instruction Dispatcher

This block sits behind a warp selector in a SIMT core. For the warp chosen in the current cycle it examines the oldest two entries of that warp's instruction buffer. It sends up to two of them to three execution pipelines: the arithmetic pipeline (SP), the special-function pipeline (SFU) and the load/store pipeline (MEM). Routing depends on each entry's operation class, on the pipeline free flags and on the scoreboard readiness of each entry.

The second entry is considered only after the first has gone out. A configuration input can require the two instructions of one cycle to use different unit types. Two saturating counters record how many cycles issued one instruction and how many issued two. A cycle in which a warp was selected but nothing left is flagged instead of counted.

The block also has a start-priority pointer for cores with several dispatchers. The pointer names the dispatcher that goes first and rotates by one every cycle.

Top module: `dual_issue_disp`

## Requirements
- R1: Operation classes 3 (load), 4 (store) and 5 (memory barrier) issue only to MEM (iss_mem), and only when mem_free is 1.
- R2: Classes 0 (plain arithmetic) and 2 (arithmetic-or-special) issue to SP when sp_free is 1 and the unit-type rule allows it. Class 1 (special function) never issues to SP.
- R3: Classes 1 and 2 issue to SFU when they did not go to SP and sfu_free is 1.
- R4: No instruction issues while sel_vld is 0, while warp_wait is 1, or while the head entry is invalid or not ready.
- R5: The next entry (bit 1 of each strobe vector) issues only if the head entry (bit 0) issued in the same cycle, cfg_dual is 1, and the next entry is valid and ready.
- R6: With cfg_diff at 1, the two instructions of one cycle never go to the same pipeline. With cfg_diff at 0 they may.
- R7: iss_cnt equals the number of instructions issued in the current cycle (0, 1 or 2).
- R8: After a cycle with iss_cnt 1, single_cnt is one higher at the next clock edge. After a cycle with iss_cnt 2, dual_cnt is one higher. Both counters stop at their all-ones value, and both are 0 after reset.
- R9: err_idle is 1 exactly when sel_vld is 1 and iss_cnt is 0. Such a cycle leaves both counters unchanged.
- R10: lead_sched is 0 after reset and advances by one modulo N_SCHED at every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_vld | input | 1 | A warp is selected this cycle |
| warp_wait | input | 1 | Selected warp is blocked |
| hd_vld | input | 1 | Head buffer entry valid |
| hd_cls | input | 3 | Head entry operation class |
| hd_rdy | input | 1 | Head entry passes scoreboard |
| nx_vld | input | 1 | Next buffer entry valid |
| nx_cls | input | 3 | Next entry operation class |
| nx_rdy | input | 1 | Next entry passes scoreboard |
| sp_free | input | 1 | SP pipeline can accept |
| sfu_free | input | 1 | SFU pipeline can accept |
| mem_free | input | 1 | MEM pipeline can accept |
| cfg_dual | input | 1 | Allow a second instruction per cycle |
| cfg_diff | input | 1 | Require distinct units for the two instructions |
| iss_sp | output | 2 | SP strobe per slot (bit 0 head, bit 1 next) |
| iss_sfu | output | 2 | SFU strobe per slot |
| iss_mem | output | 2 | MEM strobe per slot |
| iss_cnt | output | 2 | Instructions issued this cycle |
| err_idle | output | 1 | Warp selected but nothing issued |
| single_cnt | output | CNT_W | Saturating count of single-issue cycles |
| dual_cnt | output | CNT_W | Saturating count of dual-issue cycles |
| lead_sched | output | SCH_W | Dispatcher that starts first this cycle |

## Verification
The strobes, iss_cnt and err_idle are combinational from the inputs of the same cycle. The bench drives each vector at a falling edge and samples these outputs one nanosecond later, before any rising edge. The two counters and lead_sched move one rising edge after the cycle that causes the change, so the bench reads them at the falling edge that follows. The saturation checks use a narrow counter so that the all-ones value is reached within a few dozen cycles.

// File: rtl/disp_pkg.sv
package disp_pkg;
   typedef enum logic [2:0] {
      C_ALU     = 3'd0,
      C_SFU     = 3'd1,
      C_ALU_SFU = 3'd2,
      C_LOAD    = 3'd3,
      C_STORE   = 3'd4,
      C_BARRIER = 3'd5,
      C_RSV6    = 3'd6,
      C_RSV7    = 3'd7
   } op_cls_e;

   typedef enum logic [2:0] {
      U_NONE = 3'd0,
      U_SP   = 3'd1,
      U_SFU  = 3'd2,
      U_MEM  = 3'd3,
      U_DP   = 3'd4
   } unit_e;

   localparam int unsigned SLOTS = 2;

   function automatic logic cls_is_mem(op_cls_e c);
      return (c == C_LOAD) || (c == C_STORE) || (c == C_BARRIER);
   endfunction

   function automatic logic cls_sfu_ok(op_cls_e c);
      return (c == C_SFU) || (c == C_ALU_SFU);
   endfunction
endpackage

// File: rtl/disp_slot.sv
module disp_slot
   import disp_pkg::*;
(
   input  logic    try_i,
   input  op_cls_e cls_i,
   input  unit_e   prev_i,
   input  logic    diff_i,
   input  logic    sp_free_i,
   input  logic    sfu_free_i,
   input  logic    mem_free_i,
   output logic    go_o,
   output unit_e   unit_o
);
   logic blk_sp, blk_sfu, blk_mem;

   always_comb begin
      blk_sp  = diff_i && (prev_i == U_SP);
      blk_sfu = diff_i && (prev_i == U_SFU);
      blk_mem = diff_i && (prev_i == U_MEM);
   end

   always_comb begin
      go_o   = 1'b0;
      unit_o = U_NONE;
      if (try_i) begin
         if (cls_is_mem(cls_i)) begin
            if (mem_free_i && !blk_mem) begin
               go_o   = 1'b1;
               unit_o = U_MEM;
            end
         end else if (sp_free_i && (cls_i != C_SFU) && !blk_sp) begin
            go_o   = 1'b1;
            unit_o = U_SP;
         end else if (cls_sfu_ok(cls_i) && sfu_free_i && !blk_sfu) begin
            go_o   = 1'b1;
            unit_o = U_SFU;
         end
      end
   end

   // R1: a memory-class entry never leaves through SP or SFU
   always_comb begin
      if (go_o && cls_is_mem(cls_i))
         a_r1_mem_route : assert (unit_o == U_MEM);
   end
endmodule

// File: rtl/disp_tally.sv
module disp_tally #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       n_issued,
   output logic [CNT_W-1:0] single_cnt,
   output logic [CNT_W-1:0] dual_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("disp_tally: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         single_cnt <= '0;
         dual_cnt   <= '0;
      end else begin
         if (n_issued == 2'd1 && single_cnt != CNT_MAX)
            single_cnt <= single_cnt + 1'b1;
         if (n_issued == 2'd2 && dual_cnt != CNT_MAX)
            dual_cnt <= dual_cnt + 1'b1;
      end
   end

   a_r8_single_step : assert property (@(posedge clk) disable iff (!rst_n)
      (n_issued == 2'd1 && single_cnt != CNT_MAX) |=> single_cnt == $past(single_cnt) + 1'b1);
   a_r8_dual_step : assert property (@(posedge clk) disable iff (!rst_n)
      (n_issued == 2'd2 && dual_cnt != CNT_MAX) |=> dual_cnt == $past(dual_cnt) + 1'b1);
   a_r8_saturate : assert property (@(posedge clk) disable iff (!rst_n)
      (dual_cnt == CNT_MAX) |=> dual_cnt == CNT_MAX);
   a_r9_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (n_issued == 2'd0) |=> ($stable(single_cnt) && $stable(dual_cnt)));
endmodule

// File: rtl/disp_rr.sv
module disp_rr #(
   parameter int unsigned N_SCHED = 2,
   localparam int unsigned SCH_W = (N_SCHED > 1) ? $clog2(N_SCHED) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [SCH_W-1:0] lead
);
   localparam logic [SCH_W-1:0] LAST = SCH_W'(N_SCHED - 1);

   generate
      if (N_SCHED < 1) begin : g_bad_n
         $error("disp_rr: N_SCHED must be at least 1");
      end
      if (N_SCHED == 1) begin : g_single
         assign lead = '0;
      end else begin : g_rotate
         always_ff @(posedge clk) begin
            if (!rst_n)            lead <= '0;
            else if (lead == LAST) lead <= '0;
            else                   lead <= lead + 1'b1;
         end

         a_r10_rotate : assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> lead == (($past(lead) == LAST) ? '0 : $past(lead) + 1'b1));
         a_r10_range : assert property (@(posedge clk) disable iff (!rst_n)
            lead <= LAST);
      end
   endgenerate
endmodule

// File: rtl/dual_issue_disp.sv
module dual_issue_disp
   import disp_pkg::*;
#(
   parameter int unsigned MAX_ISSUE = 2,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned N_SCHED   = 2,
   localparam int unsigned SCH_W    = (N_SCHED > 1) ? $clog2(N_SCHED) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_vld,
   input  logic             warp_wait,
   input  logic             hd_vld,
   input  logic [2:0]       hd_cls,
   input  logic             hd_rdy,
   input  logic             nx_vld,
   input  logic [2:0]       nx_cls,
   input  logic             nx_rdy,
   input  logic             sp_free,
   input  logic             sfu_free,
   input  logic             mem_free,
   input  logic             cfg_dual,
   input  logic             cfg_diff,
   output logic [1:0]       iss_sp,
   output logic [1:0]       iss_sfu,
   output logic [1:0]       iss_mem,
   output logic [1:0]       iss_cnt,
   output logic             err_idle,
   output logic [CNT_W-1:0] single_cnt,
   output logic [CNT_W-1:0] dual_cnt,
   output logic [SCH_W-1:0] lead_sched
);
   generate
      if (MAX_ISSUE != 1 && MAX_ISSUE != 2) begin : g_bad_max
         $error("dual_issue_disp: MAX_ISSUE must be 1 or 2");
      end
   endgenerate

   logic    [SLOTS-1:0] try_s, go_s;
   op_cls_e             cls_s  [SLOTS];
   unit_e               prev_s [SLOTS];
   unit_e               unit_s [SLOTS];
   logic                head_ok;

   assign head_ok   = sel_vld && !warp_wait && hd_vld && hd_rdy;
   assign try_s[0]  = head_ok;
   assign cls_s[0]  = op_cls_e'(hd_cls);
   assign cls_s[1]  = op_cls_e'(nx_cls);
   assign prev_s[0] = U_NONE;
   assign prev_s[1] = unit_s[0];

   generate
      if (MAX_ISSUE == 2) begin : g_dual
         assign try_s[1] = go_s[0] && cfg_dual && nx_vld && nx_rdy && !warp_wait && sel_vld;
      end else begin : g_single
         assign try_s[1] = 1'b0;
      end

      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         disp_slot u_slot (
            .try_i      (try_s[s]),
            .cls_i      (cls_s[s]),
            .prev_i     (prev_s[s]),
            .diff_i     (cfg_diff),
            .sp_free_i  (sp_free),
            .sfu_free_i (sfu_free),
            .mem_free_i (mem_free),
            .go_o       (go_s[s]),
            .unit_o     (unit_s[s])
         );
         assign iss_sp[s]  = go_s[s] && (unit_s[s] == U_SP);
         assign iss_sfu[s] = go_s[s] && (unit_s[s] == U_SFU);
         assign iss_mem[s] = go_s[s] && (unit_s[s] == U_MEM);
      end
   endgenerate

   assign iss_cnt  = {1'b0, go_s[0]} + {1'b0, go_s[1]};
   assign err_idle = sel_vld && (iss_cnt == 2'd0);

   disp_tally #(.CNT_W(CNT_W)) u_tally (
      .clk        (clk),
      .rst_n      (rst_n),
      .n_issued   (iss_cnt),
      .single_cnt (single_cnt),
      .dual_cnt   (dual_cnt)
   );

   disp_rr #(.N_SCHED(N_SCHED)) u_rr (
      .clk  (clk),
      .rst_n(rst_n),
      .lead (lead_sched)
   );

   a_r1_mem_needs_free : assert property (@(posedge clk) disable iff (!rst_n)
      (|iss_mem) |-> mem_free);
   a_r2_sp_needs_free : assert property (@(posedge clk) disable iff (!rst_n)
      (|iss_sp) |-> sp_free);
   a_r4_blocked : assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_vld || warp_wait || !hd_vld || !hd_rdy) |-> (iss_cnt == 2'd0));
   a_r5_second_after_first : assert property (@(posedge clk) disable iff (!rst_n)
      (iss_sp[1] || iss_sfu[1] || iss_mem[1]) |-> (cfg_dual && (iss_sp[0] || iss_sfu[0] || iss_mem[0])));
   a_r6_distinct : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_diff |-> (iss_sp != 2'b11 && iss_sfu != 2'b11 && iss_mem != 2'b11));
   a_r7_one_unit_per_slot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iss_sp[0], iss_sfu[0], iss_mem[0]}) && $onehot0({iss_sp[1], iss_sfu[1], iss_mem[1]}));
   a_r7_count : assert property (@(posedge clk) disable iff (!rst_n)
      iss_cnt == 2'($countones({iss_sp, iss_sfu, iss_mem})));
endmodule

// File: tb/test_dual_issue_disp.sv
module test_dual_issue_disp;
   localparam int CW = 4;
   localparam int NS = 3;
   localparam int SW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_vld, warp_wait, hd_vld, hd_rdy, nx_vld, nx_rdy;
   logic [2:0] hd_cls, nx_cls;
   logic sp_free, sfu_free, mem_free, cfg_dual, cfg_diff;
   logic [1:0] iss_sp, iss_sfu, iss_mem, iss_cnt;
   logic err_idle;
   logic [CW-1:0] single_cnt, dual_cnt;
   logic [SW-1:0] lead_sched;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   dual_issue_disp #(.MAX_ISSUE(2), .CNT_W(CW), .N_SCHED(NS)) i_dual_issue_disp (
      .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .warp_wait(warp_wait),
      .hd_vld(hd_vld), .hd_cls(hd_cls), .hd_rdy(hd_rdy),
      .nx_vld(nx_vld), .nx_cls(nx_cls), .nx_rdy(nx_rdy),
      .sp_free(sp_free), .sfu_free(sfu_free), .mem_free(mem_free),
      .cfg_dual(cfg_dual), .cfg_diff(cfg_diff),
      .iss_sp(iss_sp), .iss_sfu(iss_sfu), .iss_mem(iss_mem), .iss_cnt(iss_cnt),
      .err_idle(err_idle), .single_cnt(single_cnt), .dual_cnt(dual_cnt),
      .lead_sched(lead_sched)
   );

   typedef struct packed {
      logic sel, wt, hv; logic [2:0] hc; logic hr, nv; logic [2:0] nc; logic nr;
      logic spf, sfuf, memf, dl, df;
      logic [1:0] esp, esfu, emem;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t TBL [NV] = '{
      // sel wt hv hc hr nv nc nr spf sfuf memf dl df esp esfu emem
      '{1,0,1,3'd0,1,0,3'd0,0,1,1,1,1,1,2'b01,2'b00,2'b00}, // R2 alu to sp
      '{1,0,1,3'd3,1,0,3'd0,0,1,1,1,1,1,2'b00,2'b00,2'b01}, // R1 load
      '{1,0,1,3'd3,1,0,3'd0,0,1,1,0,1,1,2'b00,2'b00,2'b00}, // R1 mem busy
      '{1,0,1,3'd4,1,0,3'd0,0,1,1,1,1,1,2'b00,2'b00,2'b01}, // R1 store
      '{1,0,1,3'd1,1,0,3'd0,0,1,1,1,1,1,2'b00,2'b01,2'b00}, // R3 sfu
      '{1,0,1,3'd2,1,0,3'd0,0,0,1,1,1,1,2'b00,2'b01,2'b00}, // R3 alu_sfu sp busy
      '{1,0,1,3'd2,1,0,3'd0,0,1,1,1,1,1,2'b01,2'b00,2'b00}, // R2 alu_sfu sp free
      '{1,0,1,3'd1,1,0,3'd0,0,1,0,1,1,1,2'b00,2'b00,2'b00}, // R2 sfu never sp
      '{1,0,1,3'd0,1,1,3'd3,1,1,1,1,1,1,2'b01,2'b00,2'b10}, // R5 dual alu+load
      '{1,0,1,3'd0,1,1,3'd0,1,1,1,1,1,1,2'b01,2'b00,2'b00}, // R6 diff blocks sp
      '{1,0,1,3'd0,1,1,3'd0,1,1,1,1,1,0,2'b11,2'b00,2'b00}, // R6 diff off
      '{1,0,1,3'd0,1,1,3'd2,1,1,1,1,1,1,2'b01,2'b10,2'b00}, // R6 second to sfu
      '{1,0,1,3'd4,1,1,3'd5,1,1,1,1,1,1,2'b00,2'b00,2'b01}, // R6 mem twice blocked
      '{1,0,1,3'd4,1,1,3'd5,1,1,1,1,1,0,2'b00,2'b00,2'b11}, // R6 mem twice allowed
      '{1,0,1,3'd0,1,1,3'd3,1,1,1,1,0,1,2'b01,2'b00,2'b00}, // R5 cfg_dual off
      '{1,0,1,3'd0,0,1,3'd0,1,1,1,1,1,0,2'b00,2'b00,2'b00}, // R4 head not ready
      '{1,0,1,3'd0,1,1,3'd3,0,1,1,1,1,1,2'b01,2'b00,2'b00}, // R5 next not ready
      '{1,0,1,3'd3,1,1,3'd0,1,1,1,0,1,1,2'b00,2'b00,2'b00}, // R5 head blocked
      '{1,1,1,3'd0,1,1,3'd0,1,1,1,1,1,0,2'b00,2'b00,2'b00}, // R4 waiting
      '{0,0,1,3'd0,1,1,3'd0,1,1,1,1,1,0,2'b00,2'b00,2'b00}  // R4 not selected
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      sel_vld = v.sel; warp_wait = v.wt; hd_vld = v.hv; hd_cls = v.hc; hd_rdy = v.hr;
      nx_vld = v.nv; nx_cls = v.nc; nx_rdy = v.nr;
      sp_free = v.spf; sfu_free = v.sfuf; mem_free = v.memf;
      cfg_dual = v.dl; cfg_diff = v.df;
   endtask

   task automatic idle();
      vec_t v;
      v = '0;
      drive(v);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   vec_t v_one, v_two, v_err;

   initial begin
      v_one = '{1,0,1,3'd0,1,0,3'd0,0,1,1,1,1,1,2'b01,2'b00,2'b00};
      v_two = '{1,0,1,3'd0,1,1,3'd3,1,1,1,1,1,1,2'b01,2'b00,2'b10};
      v_err = '{1,0,1,3'd3,1,0,3'd0,0,1,1,0,1,1,2'b00,2'b00,2'b00};
      idle();
      do_reset();

      // R8 R10 reset state
      chk("R8 single after reset", int'(single_cnt), 0);
      chk("R8 dual after reset", int'(dual_cnt), 0);
      chk("R10 lead after reset", int'(lead_sched), 0);
      @(negedge clk); #1 chk("R10 lead step1", int'(lead_sched), 1);
      @(negedge clk); #1 chk("R10 lead step2", int'(lead_sched), 2);
      @(negedge clk); #1 chk("R10 lead wrap", int'(lead_sched), 0);

      // vector table: combinational issue outputs
      for (int i = 0; i < NV; i++) begin
         int ec;
         @(negedge clk);
         drive(TBL[i]);
         #1;
         ec = $countones({TBL[i].esp, TBL[i].esfu, TBL[i].emem});
         chk($sformatf("R1 R2 R3 sp vec%0d", i), int'(iss_sp), int'(TBL[i].esp));
         chk($sformatf("R3 sfu vec%0d", i), int'(iss_sfu), int'(TBL[i].esfu));
         chk($sformatf("R1 mem vec%0d", i), int'(iss_mem), int'(TBL[i].emem));
         chk($sformatf("R7 count vec%0d", i), int'(iss_cnt), ec);
         chk($sformatf("R9 err vec%0d", i), int'(err_idle), int'(TBL[i].sel && ec == 0));
      end

      // R8 counting
      do_reset();
      for (int i = 0; i < 3; i++) begin drive(v_one); @(negedge clk); end
      for (int i = 0; i < 2; i++) begin drive(v_two); @(negedge clk); end
      idle(); #1;
      chk("R8 single count", int'(single_cnt), 3);
      chk("R8 dual count", int'(dual_cnt), 2);

      // R9 selected but nothing issued
      drive(v_err); #1;
      chk("R9 err flag", int'(err_idle), 1);
      @(negedge clk); idle(); #1;
      chk("R9 single unchanged", int'(single_cnt), 3);
      chk("R9 dual unchanged", int'(dual_cnt), 2);

      // R8 saturation
      for (int i = 0; i < 20; i++) begin drive(v_one); @(negedge clk); end
      idle(); #1;
      chk("R8 single saturates", int'(single_cnt), 15);
      for (int i = 0; i < 20; i++) begin drive(v_two); @(negedge clk); end
      idle(); #1;
      chk("R8 dual saturates", int'(dual_cnt), 15);
      chk("R8 single stays", int'(single_cnt), 15);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule